// File: doc/BRIEF.md
# Satellite LNB Tone Output Controller

The block generates the gated 22 kHz signalling tone carried on a satellite LNB supply line. Three register-level controls set its behaviour: `ten_i` enables the tone, `extm_i` selects external-tone mode, and `lpm_i` requests low power. A logic input pin, `dsq_i`, passes through a two-flop synchronizer inside the block. The block drives a digital tone output that feeds the analog waveform stage, and a flag that is high while the tone is gated through.

When `extm_i` is low, the pin acts as an envelope. An internal divider produces a 50% duty 22 kHz square wave, and the output carries that wave while the synchronized pin is high. Holding the pin high gives a continuous tone. When `extm_i` is high, the pin carries a 22 kHz waveform supplied from outside. An activity detector turns the output path on about 1 µs after the first pin edge. It keeps the path on for about 60 µs after the last edge, and every new edge restarts that window. All terminal counts are derived from the clock frequency parameter.

Top module: `lnb_tone_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after its release with the pin idle, `tone_o` and `tone_on_o` are 0.
- R2: When `ten_i`=0 or `lpm_i`=1, `tone_o` and `tone_on_o` are 0 in the same cycle, whatever the pin does, in either mode.
- R3: With `ten_i`=1, `lpm_i`=0 and `extm_i`=0, the tone is gated by the synchronized pin. A pin change reaches the output gating after exactly 2 rising clock edges.
- R4: The internal tone has a half-period of HALF = round(CLK_HZ / (2·TONE_HZ)) clock cycles (1136 at 50 MHz) and a 50% duty cycle. Every enable of the internal gate restarts it at the start of a high half-period.
- R5: Holding the pin high in envelope mode gives an uninterrupted internal tone, with no gap across periods.
- R6: With `ten_i`=1, `lpm_i`=0 and `extm_i`=1, while the detector is on, `tone_o` equals the synchronized pin, which lags the pin by 2 rising edges.
- R7: In external mode the detector turns on START = round(CLK_HZ·1 µs) cycles (50 at 50 MHz) after an edge is detected on the synchronized pin. This is START+3 rising edges after the pin changes.
- R8: In external mode every detected edge restarts a hold window of HOLD = round(CLK_HZ·60 µs) cycles (3000 at 50 MHz). The detector turns off HOLD+3 rising edges after the last pin change, so edges inside the window keep it on.
- R9: `tone_on_o` is high exactly while the tone path is gated on: the envelope gate in envelope mode, the detector in external mode. `tone_o` is never high while `tone_on_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ten_i | input | 1 | Tone enable control bit |
| extm_i | input | 1 | External-tone mode select bit |
| lpm_i | input | 1 | Low power request; forces the tone off |
| dsq_i | input | 1 | Asynchronous tone/envelope input pin |
| tone_o | output | 1 | Gated digital tone |
| tone_on_o | output | 1 | High while the tone path is gated on |

## Verification
A divider that loses its phase shows up on `tone_o` as a half-period that starts low after an enable, or as a high or low run that is off by one or more cycles. The bench compares every cycle of two full periods, so such a fault is caught within one half-period. A detector counter that is off by one moves the rising or falling edge of `tone_on_o` by a cycle. The bench samples both sides of each boundary, so the fault shows up exactly at START+3 or HOLD+3 edges. A synchronizer stage that is missing or extra shifts every pin-driven transition by one cycle, and this shows up on the first edge of the envelope or of the external waveform.

// File: rtl/lnb_tone_pkg.sv
package lnb_tone_pkg;

  typedef enum logic [1:0] {
    DET_IDLE = 2'd0,
    DET_ARM  = 2'd1,
    DET_ON   = 2'd2
  } det_state_e;

  // rounded count of clock cycles for num/den seconds
  function automatic int cycles_of(longint clk_hz, longint num, longint den);
    return int'((clk_hz * num + den / 2) / den);
  endfunction

endpackage

// File: rtl/lnb_pin_sync.sv
module lnb_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign edge_o  = level_o ^ last_q;

endmodule

// File: rtl/lnb_tone_div.sv
module lnb_tone_div #(
  parameter int HALF_CYC = 1136
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic phase_o
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (cnt_q == CW'(HALF_CYC - 1)) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;

  // R4
  phase_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && (phase_q != $past(phase_q))) |-> (cnt_q == '0));

  // R4
  idle_phase_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!run_i) |-> phase_q);

endmodule

// File: rtl/lnb_act_det.sv
module lnb_act_det
  import lnb_tone_pkg::*;
#(
  parameter int START_CYC = 50,
  parameter int HOLD_CYC  = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic edge_i,
  output logic on_o
);
  localparam int SW = $clog2(START_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  det_state_e    st_q;
  logic [SW-1:0] start_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= DET_IDLE;
      start_q <= '0;
      hold_q  <= '0;
    end else if (!en_i) begin
      st_q    <= DET_IDLE;
      start_q <= '0;
      hold_q  <= '0;
    end else begin
      if (edge_i)           hold_q <= HW'(HOLD_CYC - 1);
      else if (hold_q != 0) hold_q <= hold_q - 1'b1;
      unique case (st_q)
        DET_IDLE: if (edge_i) begin
          st_q    <= DET_ARM;
          start_q <= SW'(START_CYC - 1);
        end
        DET_ARM: begin
          if (start_q == '0) st_q <= DET_ON;
          else               start_q <= start_q - 1'b1;
        end
        DET_ON: if (!edge_i && hold_q == '0) st_q <= DET_IDLE;
        default: st_q <= DET_IDLE;
      endcase
    end
  end

  assign on_o = (st_q == DET_ON);

  // R7
  on_via_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == DET_ON) |-> ($past(st_q) == DET_ARM));

  // R8
  edge_keeps_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && edge_i && st_q == DET_ON) |=> (st_q == DET_ON));

  // R2
  off_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i) |-> (st_q == DET_IDLE));

endmodule

// File: rtl/lnb_tone_ctrl.sv
module lnb_tone_ctrl
  import lnb_tone_pkg::*;
#(
  parameter longint CLK_HZ  = 50_000_000,
  parameter longint TONE_HZ = 22_000,
  parameter longint START_NS = 1_000,
  parameter longint HOLD_NS  = 60_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ten_i,
  input  logic extm_i,
  input  logic lpm_i,
  input  logic dsq_i,
  output logic tone_o,
  output logic tone_on_o
);
  localparam int HALF_CYC  = cycles_of(CLK_HZ, 1, 2 * TONE_HZ);
  localparam int START_CYC = cycles_of(CLK_HZ, START_NS, 1_000_000_000);
  localparam int HOLD_CYC  = cycles_of(CLK_HZ, HOLD_NS, 1_000_000_000);

  logic pin_lvl, pin_edge;
  logic en, env_gate, ext_en, ext_gate, det_on, div_phase;

  lnb_pin_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (dsq_i),
    .level_o(pin_lvl),
    .edge_o (pin_edge)
  );

  assign en       = ten_i & ~lpm_i;
  assign env_gate = en & ~extm_i & pin_lvl;
  assign ext_en   = en & extm_i;

  lnb_tone_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (env_gate),
    .phase_o(div_phase)
  );

  lnb_act_det #(.START_CYC(START_CYC), .HOLD_CYC(HOLD_CYC)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ext_en),
    .edge_i(pin_edge),
    .on_o  (det_on)
  );

  assign ext_gate  = ext_en & det_on;
  assign tone_o    = (env_gate & div_phase) | (ext_gate & pin_lvl);
  assign tone_on_o = env_gate | ext_gate;

  // R2
  forced_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpm_i || !ten_i) |-> (!tone_o && !tone_on_o));

  // R9
  tone_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_o |-> tone_on_o);

  // R3
  env_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ten_i && !lpm_i && !extm_i && $past(ten_i && !lpm_i && !extm_i) && tone_on_o)
      |-> $past(dsq_i, 2));

endmodule

// File: tb/tb_lnb_tone_ctrl.sv
module tb_lnb_tone_ctrl;
  localparam int HALF  = (50_000_000 + 22_000) / 44_000;
  localparam int START = 50;
  localparam int HOLD  = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ten = 1'b0, extm = 1'b0, lpm = 1'b0, dsq = 1'b0;
  logic tone, tone_on;
  int   n_cmp = 0, n_bad = 0, cyc = 0;
  bit   done = 1'b0;
  logic s1 = 1'b0, s2 = 1'b0;  // synchronized-pin model

  lnb_tone_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .ten_i(ten), .extm_i(extm), .lpm_i(lpm),
    .dsq_i(dsq), .tone_o(tone), .tone_on_o(tone_on)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190_000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected < 190000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step();
    logic d = dsq;
    @(posedge clk);
    s2 = s1; s1 = (rst_n) ? d : 1'b0;
    #5;
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cyc %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic chk2(string req, logic et, logic ef);
    chk(req, tone, et);
    chk(req, tone_on, ef);
  endtask

  initial begin
    // R1 reset state
    repeat (3) step();
    chk2("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) step();
    chk2("R1", 1'b0, 1'b0);

    // R3 R4 R5 envelope mode, rising pin
    ten = 1'b1;
    repeat (4) step();
    chk2("R3", 1'b0, 1'b0);
    dsq = 1'b1;
    for (int n = 1; n <= 4 * HALF + 10; n++) begin
      step();
      if (n < 2) chk2("R3", 1'b0, 1'b0);
      else chk2("R4", (((n - 2) / HALF) % 2) == 0, 1'b1);
    end

    // R2 lpm forces off, then R4 restart at phase zero
    lpm = 1'b1;
    #1 chk2("R2", 1'b0, 1'b0);
    step();
    chk2("R2", 1'b0, 1'b0);
    lpm = 1'b0;
    for (int n = 1; n <= 2 * HALF + 5; n++) begin
      step();
      chk2("R5", ((n / HALF) % 2) == 0, 1'b1);
    end

    // R3 envelope release after 2 edges
    dsq = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      step();
      if (n >= 2) chk2("R3", 1'b0, 1'b0);
    end

    // R2 ten=0, pin toggling, both modes
    ten = 1'b0;
    for (int m = 0; m < 2; m++) begin
      extm = m[0];
      for (int n = 0; n < 300; n++) begin
        if (n % 7 == 0) dsq = ~dsq;
        step();
        chk2("R2", 1'b0, 1'b0);
      end
    end
    dsq = 1'b0;
    ten = 1'b1; lpm = 1'b1;
    for (int n = 0; n < 300; n++) begin
      if (n % 9 == 0) dsq = ~dsq;
      step();
      chk2("R2", 1'b0, 1'b0);
    end
    dsq = 1'b0; lpm = 1'b0;
    repeat (HOLD + 10) step();
    chk2("R9", 1'b0, 1'b0);

    // R7 external start latency
    dsq = 1'b1;
    for (int n = 1; n <= START + 3; n++) begin
      step();
      if (n <= START + 2) chk2("R7", 1'b0, 1'b0);
      else chk2("R7", 1'b1, 1'b1);
    end
    for (int n = 0; n < 900; n++) begin
      step();
      chk2("R6", s2, 1'b1);
    end

    // R6 R8 edges inside window keep it on; tone follows pin
    for (int k = 0; k < 5; k++) begin
      dsq = ~dsq;
      for (int n = 1; n <= 2000; n++) begin
        step();
        chk2("R6", s2, 1'b1);
        if (n == 1) chk("R6", tone, ~dsq);
        if (n == 2) chk("R6", tone, dsq);
      end
    end

    // R8 hold expiry after last change
    dsq = ~dsq;
    for (int n = 1; n <= HOLD + 3; n++) begin
      step();
      if (n <= HOLD + 2) chk2("R8", s2, 1'b1);
      else chk2("R8", 1'b0, 1'b0);
    end
    repeat (20) step();
    chk2("R9", 1'b0, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule